// File: doc/BRIEF.md
# Multi-CPU Master Interrupt Router

This block gathers 32 level-sensitive system interrupt lines into a pending word. Each implemented line can be masked through a programmable disable word. Every unmasked pending line is translated to a processor interrupt level between 1 and 15 through a fixed lookup. Several lines share a level, and some lines have no level at all. The resulting level vector is delivered to exactly one target CPU, chosen by software from up to `NCPU` processors. Every other processor sees an empty hard-level vector.

A single disable bit at the top of the disable word acts as a global gate. It stops all hard-level delivery and the level-15 broadcast, but it leaves the pending state untouched. Any line that maps to level 15 also raises a level-15 indication on every CPU at once. A display vector shows the levels of all pending lines whether they are masked or not. Software reaches the block through a word-addressed 32-bit register port. Writes are single-cycle strobes, and read data comes back registered one cycle after the address.

Top module: `irq_route`

## Requirements
- R1: After synchronous reset, the pending readback (offset 0), the disable readback (offset 1) and the target readback (offset 4) are zero. All hard-level vectors, the level-15 broadcast, the display vector and the global-off flag are also zero.
- R2: The pending word follows the source inputs every cycle, with no edge latching. Lines 23 to 26 and line 31 are never pending. A read at offset 0 returns the pending word, and its bit 31 is always zero.
- R3: The level lookup has these groups. Lines 0..6 give levels 2,3,5,7,9,11,13. Lines 7..13 repeat those same seven levels. Lines 14 and 15 give level 12. Line 16 gives 6, line 17 gives 13, line 18 gives 4, line 19 gives 10, line 20 gives 8, line 21 gives 9 and line 22 gives 11. Lines 27..30 give level 15. Lines 23..26 and 31 have no level. Bit k of a level vector means level k, and bit 0 is never set.
- R4: Only disable bits in mask 0xF05DFF80 are writable. A write to offset 3 sets the disable bits that are one in the data. A write to offset 2 clears the disable bits that are one in the data. Bits outside the mask keep their reset value, so lines 0..6 stay masked forever. A read at offset 1 returns the disable word ANDed with 0xF05DFF80.
- R5: Setting a disable bit never clears the matching pending bit.
- R6: A write to offset 4 keeps the low log2(NCPU) data bits as the target CPU. Only the target's hard vector can be nonzero. That vector holds the levels of pending lines whose disable bit is clear.
- R7: While disable bit 31 is set, the global-off output is high and every hard vector and the level-15 broadcast are zero. The pending readback is unaffected.
- R8: While any of lines 27..30 is pending and disable bit 31 is clear, the level-15 broadcast is high on every CPU. This holds regardless of the per-line disable bits.
- R9: The display vector holds the levels of every pending line, regardless of any disable bit.
- R10: Reads of offsets 5..7 return zero. Writes to offsets 0, 1 and 5..7 change no state.
- R11: The outputs reflect a source change two clock edges after it and a register write one edge after the write edge. Read data appears one edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-sensitive system interrupt lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Registered read data for the previous cycle's offset |
| cpu_hard_o | output | NCPU*16 | Hard-level vector per CPU, CPU c in bits [16c+15:16c] |
| cpu_l15_o | output | NCPU | Level-15 broadcast per CPU |
| tgt_disp_o | output | 16 | Levels of all pending lines, unmasked |
| master_off_o | output | 1 | Global delivery disable flag |

## Verification
A source change is captured into the pending word at the first edge and reaches the registered outputs at the second edge. The bench therefore changes sources on a falling edge and compares the outputs two falling edges later. One check confirms that the outputs still hold the old value after only one edge. A register write becomes state at its own edge and reaches the outputs at the next edge. The bench waits out both before comparing. Reads present the offset on a falling edge and sample the data on the following falling edge.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NSRC   = 32;
  localparam int NLVL   = 16;
  localparam int ADDR_W = 3;
  localparam int MSTR_BIT = 31;
  localparam logic [NSRC-1:0] IMPL_MASK = 32'hF05DFF80;

  // source line -> processor level, 0 = no level
  localparam logic [3:0] LVL_TAB [NSRC] = '{
    4'd2, 4'd3, 4'd5, 4'd7, 4'd9, 4'd11, 4'd13,
    4'd2, 4'd3, 4'd5, 4'd7, 4'd9, 4'd11, 4'd13,
    4'd12, 4'd12, 4'd6, 4'd13, 4'd4, 4'd10, 4'd8, 4'd9, 4'd11,
    4'd0, 4'd0, 4'd0, 4'd0,
    4'd15, 4'd15, 4'd15, 4'd15,
    4'd0
  };

  typedef enum logic [ADDR_W-1:0] {
    OFF_PEND = 3'd0,
    OFF_MASK = 3'd1,
    OFF_UNMASK = 3'd2,
    OFF_SETMASK = 3'd3,
    OFF_TARGET = 3'd4
  } reg_off_e;
endpackage

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_route_pkg::*;
(
  input  logic [NSRC-1:0] bits_i,
  output logic [NLVL-1:0] lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int j = 0; j < NSRC; j++) begin
      if (bits_i[j] && (LVL_TAB[j] != 4'd0))
        lvl_o[LVL_TAB[j]] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int CPU_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic [NSRC-1:0]   pend_o,
  output logic [NSRC-1:0]   mask_o,
  output logic [CPU_W-1:0]  tgt_o
);
  logic [NSRC-1:0] live_lines;
  logic [NSRC-1:0] wmask;

  always_comb begin
    for (int j = 0; j < NSRC; j++)
      live_lines[j] = (LVL_TAB[j] != 4'd0);
  end

  assign wmask = wdata_i & IMPL_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
      mask_o <= ~IMPL_MASK;
      tgt_o  <= '0;
    end else begin
      pend_o <= src_i & live_lines;
      if (wr_i) begin
        case (addr_i)
          OFF_UNMASK:  mask_o <= mask_o & ~wmask;
          OFF_SETMASK: mask_o <= mask_o | wmask;
          OFF_TARGET:  tgt_o  <= wdata_i[CPU_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      case (addr_i)
        OFF_PEND:   rdata_o <= pend_o & ~(NSRC'(1) << MSTR_BIT);
        OFF_MASK:   rdata_o <= mask_o & IMPL_MASK;
        OFF_TARGET: rdata_o <= {{(NSRC-CPU_W){1'b0}}, tgt_o};
        default:    rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_cpu_steer.sv
module irq_cpu_steer
  import irq_route_pkg::*;
#(
  parameter int NCPU  = 16,
  parameter int CPU_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NLVL-1:0]      open_lvl_i,
  input  logic [NLVL-1:0]      all_lvl_i,
  input  logic                 gate_off_i,
  input  logic [CPU_W-1:0]     tgt_i,
  output logic [NCPU*NLVL-1:0] hard_o,
  output logic [NCPU-1:0]      l15_o,
  output logic [NLVL-1:0]      disp_o,
  output logic                 off_o
);
  logic l15_next;
  assign l15_next = all_lvl_i[NLVL-1] && !gate_off_i;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst) begin
        hard_o[c*NLVL +: NLVL] <= '0;
        l15_o[c] <= 1'b0;
      end else begin
        hard_o[c*NLVL +: NLVL] <= (tgt_i == CPU_W'(c) && !gate_off_i) ?
                                  open_lvl_i : '0;
        l15_o[c] <= l15_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_o <= '0;
      off_o  <= 1'b0;
    end else begin
      disp_o <= all_lvl_i;
      off_o  <= gate_off_i;
    end
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_route_pkg::*;
#(
  parameter int NCPU = 16,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [31:0]          src_i,
  input  logic                 bus_wr_i,
  input  logic [2:0]           bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic [NCPU*16-1:0]   cpu_hard_o,
  output logic [NCPU-1:0]      cpu_l15_o,
  output logic [15:0]          tgt_disp_o,
  output logic                 master_off_o
);
  logic [NSRC-1:0]  pend_q;
  logic [NSRC-1:0]  mask_q;
  logic [CPU_W-1:0] tgt_q;
  logic [NLVL-1:0]  open_lvl;
  logic [NLVL-1:0]  all_lvl;

  irq_route_regs #(.CPU_W(CPU_W)) u_regs (
    .clk(clk), .rst(rst), .src_i(src_i),
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .pend_o(pend_q), .mask_o(mask_q), .tgt_o(tgt_q)
  );

  irq_level_map u_map_open (.bits_i(pend_q & ~mask_q), .lvl_o(open_lvl));
  irq_level_map u_map_all  (.bits_i(pend_q),           .lvl_o(all_lvl));

  irq_cpu_steer #(.NCPU(NCPU), .CPU_W(CPU_W)) u_steer (
    .clk(clk), .rst(rst),
    .open_lvl_i(open_lvl), .all_lvl_i(all_lvl),
    .gate_off_i(mask_q[MSTR_BIT]), .tgt_i(tgt_q),
    .hard_o(cpu_hard_o), .l15_o(cpu_l15_o),
    .disp_o(tgt_disp_o), .off_o(master_off_o)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NCPU = 16,
  parameter int CPU_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr_i,
  input logic [2:0]         bus_addr_i,
  input logic [31:0]        bus_wdata_i,
  input logic [31:0]        bus_rdata_o,
  input logic [NCPU*16-1:0] cpu_hard_o,
  input logic [NCPU-1:0]    cpu_l15_o,
  input logic               master_off_o,
  input logic [CPU_W-1:0]   tgt_q
);
  logic [NCPU-1:0] busy;
  logic [NCPU-1:0] zero_bit;
  for (genvar c = 0; c < NCPU; c++) begin : g_nz
    assign busy[c]     = |cpu_hard_o[c*16 +: 16];
    assign zero_bit[c] = cpu_hard_o[c*16];
  end

  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(busy) <= 1);

  // R3
  no_level_zero_chk: assert property (@(posedge clk) disable iff (rst)
    zero_bit == '0);

  // R7
  gate_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    master_off_o |-> (cpu_hard_o == '0 && cpu_l15_o == '0));

  // R8
  l15_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_l15_o == '0) || (cpu_l15_o == '1));

  // R2
  pend_top_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_i == 3'd0) |=> !bus_rdata_o[31]);

  // R4
  mask_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_i == 3'd1) |=> ((bus_rdata_o & ~32'hF05DFF80) == 32'h0));

  // R6
  target_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == 3'd4) |=> (tgt_q == $past(bus_wdata_i[CPU_W-1:0])));

  // R10
  hole_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_i >= 3'd5) |=> (bus_rdata_o == 32'h0));
endmodule

bind irq_route irq_route_chk #(.NCPU(NCPU), .CPU_W(CPU_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .cpu_hard_o(cpu_hard_o), .cpu_l15_o(cpu_l15_o),
  .master_off_o(master_off_o), .tgt_q(tgt_q)
);

// File: tb/test_irq_route.sv
`timescale 1ns/1ps
module test_irq_route;
  localparam int NCPU = 16;
  localparam logic [31:0] IMPL  = 32'hF05DFF80;
  localparam logic [31:0] LIVE  = 32'h787FFFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] src = '0;
  logic wr = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCPU*16-1:0] hard;
  logic [NCPU-1:0] l15;
  logic [15:0] disp;
  logic moff;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_mask;
  int m_tgt;

  always #2.5 clk = ~clk;

  irq_route #(.NCPU(NCPU)) i_irq_route (
    .clk(clk), .rst(rst), .src_i(src), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cpu_hard_o(hard),
    .cpu_l15_o(l15), .tgt_disp_o(disp), .master_off_o(moff)
  );

  function automatic int lvl_of(int b);
    if (b <= 13) begin
      case (b % 7)
        0: return 2; 1: return 3; 2: return 5; 3: return 7;
        4: return 9; 5: return 11; default: return 13;
      endcase
    end
    case (b)
      14, 15: return 12;
      16: return 6; 17: return 13; 18: return 4; 19: return 10;
      20: return 8; 21: return 9; 22: return 11;
      27, 28, 29, 30: return 15;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] lvl_vec(logic [31:0] v);
    logic [15:0] r = '0;
    for (int j = 0; j < 32; j++)
      if (v[j] && lvl_of(j) != 0) r[lvl_of(j)] = 1'b1;
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    addr = 3'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    case (a)
      2: m_mask = m_mask & ~(d & IMPL);
      3: m_mask = m_mask | (d & IMPL);
      4: m_tgt = int'(d[3:0]);
      default: ;
    endcase
  endtask

  task automatic rd_reg(int a, output logic [31:0] d);
    addr = 3'(a);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic check_outs(string req);
    logic [31:0] p = src & LIVE;
    logic [15:0] open_v = m_mask[31] ? 16'h0 : lvl_vec(p & ~m_mask);
    for (int c = 0; c < NCPU; c++)
      check(req, 32'(hard[c*16 +: 16]), (c == m_tgt) ? 32'(open_v) : 32'h0);
    check(req, 32'(l15), ((|p[30:27]) && !m_mask[31]) ? 32'hFFFF : 32'h0);
    check(req, 32'(disp), 32'(lvl_vec(p)));
    check(req, 32'(moff), 32'(m_mask[31]));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] lf;
    m_mask = ~IMPL;
    m_tgt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", 32'(hard), 32'h0);
    check("R1", 32'(l15), 32'h0);
    check("R1", {16'h0, disp}, 32'h0);
    check("R1", 32'(moff), 32'h0);
    rd_reg(0, d); check("R1", d, 32'h0);
    rd_reg(1, d); check("R1", d, 32'h0);
    rd_reg(4, d); check("R1", d, 32'h0);

    // R4 set / clear of the mask
    wr_reg(3, 32'hFFFFFFFF);
    rd_reg(1, d); check("R4", d, IMPL);
    @(negedge clk); check("R7", 32'(moff), 32'h1);
    wr_reg(2, 32'h80000000);
    rd_reg(1, d); check("R4", d, 32'h705DFF80);
    wr_reg(2, 32'hFFFFFFFF);
    rd_reg(1, d); check("R4", d, 32'h0);

    // R11 timing of a source change
    settle();
    src = 32'h00000100;
    @(negedge clk); check("R11", 32'(disp), 32'h0);
    @(negedge clk); check("R11", 32'(disp), 32'h0008);
    check_outs("R11");

    // R2 R3 R6 R8 R9 sweep over every line, target walks with it
    for (int j = 0; j < 32; j++) begin
      wr_reg(4, 32'hABCD0000 | 32'(j));
      src = 32'h1 << j;
      settle();
      check_outs("R3");
      rd_reg(0, d); check("R2", d, src & LIVE);
      rd_reg(4, d); check("R6", d, 32'(j % 16));
    end

    // R5 masking keeps pending
    src = 32'h7FFFFFFF;
    wr_reg(3, 32'h0005FF00);
    settle();
    check_outs("R5");
    rd_reg(0, d); check("R5", d, 32'h787FFFFF);

    // R7 global gate
    src = 32'h10000010;
    wr_reg(3, 32'h80000000);
    settle();
    check_outs("R7");
    rd_reg(0, d); check("R7", d, 32'h10000010);
    wr_reg(2, 32'h80000000);
    settle();
    check_outs("R8");

    // R10 holes and read-only offsets
    wr_reg(5, 32'hFFFFFFFF); wr_reg(6, 32'hFFFFFFFF);
    wr_reg(7, 32'hFFFFFFFF); wr_reg(0, 32'hFFFFFFFF); wr_reg(1, 32'hFFFFFFFF);
    rd_reg(1, d); check("R10", d, m_mask & IMPL);
    rd_reg(4, d); check("R10", d, 32'(m_tgt));
    rd_reg(5, d); check("R10", d, 32'h0);
    rd_reg(6, d); check("R10", d, 32'h0);
    rd_reg(7, d); check("R10", d, 32'h0);
    settle();
    check_outs("R10");

    // mixed patterns
    lf = 32'h1D872B41;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      src = lf;
      wr_reg((k % 2 == 0) ? 3 : 2, {lf[7:0], lf[31:8]});
      wr_reg(4, lf ^ 32'(k));
      settle();
      check_outs("R6");
      rd_reg(1, d); check("R4", d, m_mask & IMPL);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule